// File: doc/BRIEF.md
# Four-Lane Mixed-Format Dot-Product Accumulator

This block multiplies four operand pairs per cycle and adds the four products into a running fixed-point sum. The operands are signed 8-bit integers, pairs of signed 4-bit integers, 8-bit floating-point values (4 exponent bits, 3 mantissa bits), or signed 8-bit integers that share one block exponent. For floating-point operands each lane forms its own product exponent. The largest of the four is taken as the block reference, and every lane's significand product is right-shifted by its distance from that reference inside the product path. Because of this, a plain two's-complement adder tree forms the block sum and no floating-point adder is needed.

The result is an integer accumulator `acc_o` and a signed exponent `acc_exp_o`. The accumulated value is `acc_o * 2^acc_exp_o`. When a new block arrives with a different exponent, the operand with the smaller exponent is shifted right before the add. A clear input restarts the sum. Each lane multiplier is built from four 4x4 sub-multipliers: they are fused for 8-bit work and used as two independent products for 4-bit work. A single shifter per lane serves all of its sub-multipliers.

Top module: `mixfmt_dot4`

## Requirements
- R1: With `fmt`=0 (INT8), byte l of `a_ops` and of `b_ops` (bits 8l+7..8l) is a signed 8-bit value. The block sum is the exact sum of the four products, and the block exponent is 0.
- R2: With `fmt`=1 (INT4), each byte holds two signed 4-bit values, bits 3..0 and bits 7..4. A lane contributes low*low + high*high, and the block exponent is 0.
- R3: With `fmt`=2 (FP8), bit 7 is the sign, bits 6..3 are the exponent field (bias 7) and bits 2..0 are the mantissa. A non-zero field gives significand 8+mantissa. A zero field is treated as exponent 1 with significand equal to the mantissa.
- R4: In FP8 the lane product exponent is ea+eb-14 and emax is the largest of the four. A lane adds (sa*sb*16) >> (emax - its exponent), truncated, and negated afterwards when the signs differ. Shifts of 20 or more give 0. The block exponent is emax-10.
- R5: With `fmt`=3 (MXINT), the lanes are signed 8-bit products with no alignment shift, and the block exponent is the sign-extended `shared_exp`.
- R6: When a block is accepted into a non-empty accumulator, the one with the smaller exponent is arithmetically shifted right by the exponent difference before the add. The stored exponent becomes the larger of the two.
- R7: `clr` without `in_valid` sets the accumulator and exponent to 0 one cycle later. `clr` together with `in_valid` discards the old sum and loads the new block alone.
- R8: The first block accepted after reset or a clear is loaded as-is, with its own exponent, whether that exponent is above or below 0.
- R9: `out_valid` is high in exactly the cycle after each accepted input. `acc_o` and `acc_exp_o` change only on an accepted input or a clear.
- R10: After reset `acc_o`=0, `acc_exp_o`=0 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| clr | input | 1 | Restart the accumulation |
| fmt | input | 2 | 0 INT8, 1 INT4, 2 FP8, 3 MXINT |
| shared_exp | input | SHX_W (8) | Signed block exponent for MXINT |
| a_ops | input | LANES*8 (32) | First operand of each lane |
| b_ops | input | LANES*8 (32) | Second operand of each lane |
| acc_o | output | ACC_W (32) | Signed accumulator value |
| acc_exp_o | output | EXP_W (10) | Signed exponent of the accumulator |
| out_valid | output | 1 | A block was absorbed on the last edge |

## Verification
Integer blocks with extreme values such as -128*-128 and -8*-8 separate exact sign-magnitude multiplication from faulty fusing or faulty splitting of the sub-multipliers. FP8 blocks use equal exponents, moderately spread exponents, subnormals and a spread wide enough to flush a lane. These show whether the reference, the per-lane shift and the negate-after-truncate order are right. MXINT blocks whose shared exponents rise, fall and become negative exercise both directions of accumulator alignment and the first-block load. A long mixed random run with sporadic clears checks the format switching and the R6 and R7 interplay on every clock.

// File: rtl/mixfmt_pkg.sv
package mixfmt_pkg;

  typedef enum logic [1:0] {
    FMT_INT8  = 2'd0,
    FMT_INT4  = 2'd1,
    FMT_FP8   = 2'd2,
    FMT_MXINT = 2'd3
  } fmt_e;

  localparam int FP_BIAS  = 7;
  localparam int FP_MAN_W = 3;
  localparam int PE_W     = 7;   // holds ea+eb-2*bias, range -12..16
  localparam int PROD_W   = 16;  // fused 8x8 magnitude product

  // magnitude of a signed byte (128 fits in 8 unsigned bits)
  function automatic logic [7:0] mag8(input logic [7:0] x);
    return x[7] ? (~x + 8'd1) : x;
  endfunction

  function automatic logic [3:0] mag4(input logic [3:0] x);
    return x[3] ? (~x + 4'd1) : x;
  endfunction

  // significand with hidden bit; zero exponent field means subnormal
  function automatic logic [FP_MAN_W:0] fp_sig(input logic [7:0] x);
    return {|x[6:3], x[2:0]};
  endfunction

  function automatic logic [3:0] fp_eeff(input logic [7:0] x);
    return (x[6:3] == 4'd0) ? 4'd1 : x[6:3];
  endfunction

  function automatic logic signed [PE_W-1:0] fp_pexp(input logic [7:0] a,
                                                     input logic [7:0] b);
    logic [PE_W-1:0] sum;
    sum = {3'b000, fp_eeff(a)} + {3'b000, fp_eeff(b)} - PE_W'(2*FP_BIAS);
    return $signed(sum);
  endfunction

endpackage

// File: rtl/mixfmt_lane.sv
module mixfmt_lane
  import mixfmt_pkg::*;
#(
  parameter int FRAC = 4,
  parameter int SH_W = 6,
  localparam int MAG_W  = PROD_W + FRAC,
  localparam int TERM_W = MAG_W + 1
) (
  input  fmt_e                      fmt,
  input  logic [7:0]                a,
  input  logic [7:0]                b,
  input  logic [SH_W-1:0]           shamt,
  output logic signed [TERM_W-1:0]  term
);

  logic [7:0]        ma, mb;
  logic              neg;
  logic [7:0]        pp [2][2];
  logic [PROD_W-1:0] prod;
  logic [MAG_W-1:0]  pre;
  logic [MAG_W-1:0]  shifted;
  logic signed [TERM_W-1:0] fused_term, int4_term, t_lo, t_hi;

  // operand conditioning into sign-magnitude
  always_comb begin
    unique case (fmt)
      FMT_FP8: begin
        ma = {4'b0000, fp_sig(a)};
        mb = {4'b0000, fp_sig(b)};
      end
      FMT_INT4: begin
        ma = {mag4(a[7:4]), mag4(a[3:0])};
        mb = {mag4(b[7:4]), mag4(b[3:0])};
      end
      default: begin
        ma = mag8(a);
        mb = mag8(b);
      end
    endcase
  end

  assign neg = a[7] ^ b[7];

  // 2x2 grid of 4x4 sub-multipliers
  for (genvar i = 0; i < 2; i++) begin : g_row
    for (genvar j = 0; j < 2; j++) begin : g_col
      assign pp[i][j] = {4'b0000, ma[4*i +: 4]} * {4'b0000, mb[4*j +: 4]};
    end
  end

  // fused 8x8 from the four partials
  assign prod = {8'b0, pp[0][0]}
              + ({8'b0, pp[0][1]} << 4)
              + ({8'b0, pp[1][0]} << 4)
              + ({8'b0, pp[1][1]} << 8);

  // FP products carry FRAC extra low bits so alignment keeps some fraction
  assign pre = (fmt == FMT_FP8) ? {prod, {FRAC{1'b0}}} : {{FRAC{1'b0}}, prod};

  // the single shifter that all four sub-multipliers of this lane share
  assign shifted = (int'(shamt) >= MAG_W) ? '0 : (pre >> shamt);

  assign fused_term = neg ? -$signed({1'b0, shifted}) : $signed({1'b0, shifted});

  // split mode: diagonal partials are two independent signed products
  assign t_lo = $signed({{(TERM_W-8){1'b0}}, pp[0][0]});
  assign t_hi = $signed({{(TERM_W-8){1'b0}}, pp[1][1]});
  assign int4_term = ((a[3] ^ b[3]) ? -t_lo : t_lo)
                   + ((a[7] ^ b[7]) ? -t_hi : t_hi);

  assign term = (fmt == FMT_INT4) ? int4_term : fused_term;

endmodule

// File: rtl/mixfmt_expmax.sv
module mixfmt_expmax
  import mixfmt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SH_W  = 6
) (
  input  fmt_e                            fmt,
  input  logic [LANES-1:0][PE_W-1:0]      pexp,
  output logic signed [PE_W-1:0]          emax,
  output logic [LANES-1:0][SH_W-1:0]      shamt
);

  logic signed [PE_W-1:0] diff [LANES];

  always_comb begin
    emax = $signed(pexp[0]);
    for (int l = 1; l < LANES; l++) begin
      if ($signed(pexp[l]) > emax) emax = $signed(pexp[l]);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_sh
    assign diff[l]  = emax - $signed(pexp[l]);
    assign shamt[l] = (fmt == FMT_FP8) ? SH_W'(diff[l]) : '0;
  end

endmodule

// File: rtl/mixfmt_tree.sv
module mixfmt_tree #(
  parameter int LANES = 4,
  parameter int IN_W  = 21,
  localparam int OUT_W = IN_W + $clog2(LANES)
) (
  input  logic [LANES-1:0][IN_W-1:0] terms,
  output logic signed [OUT_W-1:0]    sum
);

  // heap-ordered binary tree: node k adds nodes 2k+1 and 2k+2
  logic signed [OUT_W-1:0] node [2*LANES-1];

  for (genvar l = 0; l < LANES; l++) begin : g_leaf
    assign node[LANES-1+l] = {{(OUT_W-IN_W){terms[l][IN_W-1]}}, terms[l]};
  end

  for (genvar k = 0; k < LANES-1; k++) begin : g_add
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign sum = node[0];

endmodule

// File: rtl/mixfmt_acc.sv
module mixfmt_acc #(
  parameter int ACC_W = 32,
  parameter int EXP_W = 10,
  parameter int BS_W  = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_valid,
  input  logic signed [BS_W-1:0]   bsum,
  input  logic signed [EXP_W-1:0]  bexp,
  output logic signed [ACC_W-1:0]  acc_q,
  output logic signed [EXP_W-1:0]  exp_q,
  output logic                     empty_q,
  output logic                     ov_q
);

  logic                    fresh;
  logic signed [EXP_W:0]   diff;
  logic [EXP_W:0]          dmag;
  logic signed [ACC_W-1:0] bs_ext;
  logic signed [ACC_W-1:0] nxt_acc;
  logic signed [EXP_W-1:0] nxt_exp;

  assign fresh  = empty_q | clr;
  assign diff   = {bexp[EXP_W-1], bexp} - {exp_q[EXP_W-1], exp_q};
  assign dmag   = diff[EXP_W] ? (~diff + 1'b1) : diff;
  assign bs_ext = {{(ACC_W-BS_W){bsum[BS_W-1]}}, bsum};

  always_comb begin
    if (fresh) begin
      nxt_acc = bs_ext;
      nxt_exp = bexp;
    end else if (!diff[EXP_W] && diff != '0) begin
      nxt_acc = (acc_q >>> dmag) + bs_ext;
      nxt_exp = bexp;
    end else begin
      nxt_acc = acc_q + (bs_ext >>> dmag);
      nxt_exp = exp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      exp_q   <= '0;
      empty_q <= 1'b1;
      ov_q    <= 1'b0;
    end else begin
      ov_q <= in_valid;
      if (in_valid) begin
        acc_q   <= nxt_acc;
        exp_q   <= nxt_exp;
        empty_q <= 1'b0;
      end else if (clr) begin
        acc_q   <= '0;
        exp_q   <= '0;
        empty_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mixfmt_dot4.sv
module mixfmt_dot4
  import mixfmt_pkg::*;
#(
  parameter int LANES = 4,
  parameter int FRAC  = 4,
  parameter int ACC_W = 32,
  parameter int EXP_W = 10,
  parameter int SHX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 clr,
  input  logic [1:0]           fmt,
  input  logic [SHX_W-1:0]     shared_exp,
  input  logic [LANES*8-1:0]   a_ops,
  input  logic [LANES*8-1:0]   b_ops,
  output logic [ACC_W-1:0]     acc_o,
  output logic [EXP_W-1:0]     acc_exp_o,
  output logic                 out_valid
);

  localparam int SH_W   = 6;
  localparam int MAG_W  = PROD_W + FRAC;
  localparam int TERM_W = MAG_W + 1;
  localparam int BS_W   = TERM_W + $clog2(LANES);
  localparam int FP_OFF = 2*FP_MAN_W + FRAC;

  fmt_e                          fmt_q;
  logic [LANES-1:0][PE_W-1:0]    lane_pexp;
  logic signed [PE_W-1:0]        emax;
  logic [LANES-1:0][SH_W-1:0]    lane_shamt;
  logic [LANES-1:0][TERM_W-1:0]  lane_term;
  logic signed [BS_W-1:0]        blk_sum;
  logic signed [EXP_W-1:0]       blk_exp;
  logic signed [ACC_W-1:0]       acc_s;
  logic signed [EXP_W-1:0]       exp_s;
  logic                          acc_empty;

  assign fmt_q = fmt_e'(fmt);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_pexp[l] = fp_pexp(a_ops[8*l +: 8], b_ops[8*l +: 8]);

    mixfmt_lane #(.FRAC(FRAC), .SH_W(SH_W)) u_lane (
      .fmt   (fmt_q),
      .a     (a_ops[8*l +: 8]),
      .b     (b_ops[8*l +: 8]),
      .shamt (lane_shamt[l]),
      .term  (lane_term[l])
    );
  end

  mixfmt_expmax #(.LANES(LANES), .SH_W(SH_W)) u_emax (
    .fmt   (fmt_q),
    .pexp  (lane_pexp),
    .emax  (emax),
    .shamt (lane_shamt)
  );

  mixfmt_tree #(.LANES(LANES), .IN_W(TERM_W)) u_tree (
    .terms (lane_term),
    .sum   (blk_sum)
  );

  always_comb begin
    unique case (fmt_q)
      FMT_FP8:   blk_exp = {{(EXP_W-PE_W){emax[PE_W-1]}}, emax} - EXP_W'(FP_OFF);
      FMT_MXINT: blk_exp = {{(EXP_W-SHX_W){shared_exp[SHX_W-1]}}, shared_exp};
      default:   blk_exp = '0;
    endcase
  end

  mixfmt_acc #(.ACC_W(ACC_W), .EXP_W(EXP_W), .BS_W(BS_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .bsum     (blk_sum),
    .bexp     (blk_exp),
    .acc_q    (acc_s),
    .exp_q    (exp_s),
    .empty_q  (acc_empty),
    .ov_q     (out_valid)
  );

  assign acc_o     = acc_s;
  assign acc_exp_o = exp_s;

endmodule

// File: rtl/mixfmt_dot4_chk.sv
module mixfmt_dot4_chk #(
  parameter int LANES = 4,
  parameter int ACC_W = 32,
  parameter int EXP_W = 10,
  parameter int SH_W  = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         clr,
  input logic [1:0]                   fmt,
  input logic [ACC_W-1:0]             acc_o,
  input logic [EXP_W-1:0]             acc_exp_o,
  input logic                         out_valid,
  input logic                         acc_empty,
  input logic [LANES-1:0][SH_W-1:0]   lane_shamt
);

  logic has_zero;
  logic signed [EXP_W-1:0] exp_s;

  assign exp_s = acc_exp_o;

  always_comb begin
    has_zero = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_shamt[l] == '0) has_zero = 1'b1;
    end
  end

  // R9
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !in_valid |=> acc_o == '0 && acc_exp_o == '0 && acc_empty);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !clr |=> $stable(acc_o) && $stable(acc_exp_o));

  // R5
  no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt != 2'd2 |-> lane_shamt == '0);

  // R4
  ref_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt == 2'd2 |-> has_zero);

  // R6
  exp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !acc_empty |=> exp_s >= $past(exp_s));

endmodule

bind mixfmt_dot4 mixfmt_dot4_chk #(
  .LANES(LANES), .ACC_W(ACC_W), .EXP_W(EXP_W), .SH_W(SH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .clr        (clr),
  .fmt        (fmt),
  .acc_o      (acc_o),
  .acc_exp_o  (acc_exp_o),
  .out_valid  (out_valid),
  .acc_empty  (acc_empty),
  .lane_shamt (lane_shamt)
);

// File: tb/sim_mixfmt_dot4.sv
module sim_mixfmt_dot4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        clr = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [7:0]  shared_exp = 8'd0;
  logic [31:0] a_ops = '0;
  logic [31:0] b_ops = '0;
  logic [31:0] acc_o;
  logic [9:0]  acc_exp_o;
  logic        out_valid;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  logic signed [31:0] m_acc = 0;
  int                 m_exp = 0;
  bit                 m_empty = 1;
  bit                 m_ov = 0;

  always #10 clk = ~clk;

  mixfmt_dot4 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr(clr), .fmt(fmt),
    .shared_exp(shared_exp), .a_ops(a_ops), .b_ops(b_ops),
    .acc_o(acc_o), .acc_exp_o(acc_exp_o), .out_valid(out_valid)
  );

  function automatic int s8(input logic [7:0] x);
    return x[7] ? int'(x) - 256 : int'(x);
  endfunction

  function automatic int s4(input logic [3:0] x);
    return x[3] ? int'(x) - 16 : int'(x);
  endfunction

  // value of one block as integer sum and exponent
  task automatic block_value(input logic [1:0] f, input logic [7:0] shx,
                             input logic [31:0] a, input logic [31:0] b,
                             output longint s, output int e);
    int pe [4];
    int sp [4];
    bit ng [4];
    int emax;
    s = 0;
    e = 0;
    emax = -1000;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] x, y;
      x = a[8*l +: 8];
      y = b[8*l +: 8];
      case (f)
        2'd0, 2'd3: s += s8(x) * s8(y);
        2'd1: s += s4(x[3:0]) * s4(y[3:0]) + s4(x[7:4]) * s4(y[7:4]);
        default: begin
          int ex, ey, gx, gy;
          ex = (x[6:3] == 0) ? 1 : int'(x[6:3]);
          ey = (y[6:3] == 0) ? 1 : int'(y[6:3]);
          gx = (x[6:3] == 0) ? int'(x[2:0]) : 8 + int'(x[2:0]);
          gy = (y[6:3] == 0) ? int'(y[2:0]) : 8 + int'(y[2:0]);
          pe[l] = ex + ey - 14;
          sp[l] = gx * gy * 16;
          ng[l] = x[7] ^ y[7];
          if (pe[l] > emax) emax = pe[l];
        end
      endcase
    end
    if (f == 2'd2) begin
      for (int l = 0; l < 4; l++) begin
        int m;
        m = sp[l] >> (emax - pe[l]);
        s += ng[l] ? -m : m;
      end
      e = emax - 10;
    end
    if (f == 2'd3) e = s8(shx);
  endtask

  task automatic model_step(input bit v, input bit c, input logic [1:0] f,
                            input logic [7:0] shx, input logic [31:0] a,
                            input logic [31:0] b);
    longint bs;
    int be;
    logic signed [31:0] bsx;
    m_ov = v;
    if (v) begin
      block_value(f, shx, a, b, bs, be);
      bsx = 32'(bs);
      if (m_empty || c) begin
        m_acc = bsx;
        m_exp = be;
      end else if (be > m_exp) begin
        m_acc = (m_acc >>> (be - m_exp)) + bsx;
        m_exp = be;
      end else begin
        m_acc = m_acc + (bsx >>> (m_exp - be));
      end
      m_empty = 0;
    end else if (c) begin
      m_acc = 0;
      m_exp = 0;
      m_empty = 1;
    end
  endtask

  task automatic compare(input string tag);
    n_run++;
    if (acc_o !== m_acc || $signed(acc_exp_o) != m_exp || out_valid !== m_ov) begin
      n_fail++;
      $display("FAIL %s: actual acc=%0d exp=%0d v=%0b expected acc=%0d exp=%0d v=%0b",
               tag, $signed(acc_o), $signed(acc_exp_o), out_valid,
               m_acc, m_exp, m_ov);
    end
  endtask

  // drive on the falling edge, sample midway after the rising edge
  task automatic cycle(input bit v, input bit c, input logic [1:0] f,
                       input logic [7:0] shx, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    @(negedge clk);
    in_valid = v; clr = c; fmt = f; shared_exp = shx; a_ops = a; b_ops = b;
    model_step(v, c, f, shx, a, b);
    @(posedge clk);
    #5;
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R10 reset state
    cycle(0, 0, 2'd0, 8'd0, 32'h0, 32'h0, "R10");

    // R1 INT8 with extreme values, then accumulate at equal exponent
    cycle(1, 1, 2'd0, 8'd0, 32'h7F80FF05, 32'h8080FFFD, "R1");
    cycle(1, 0, 2'd0, 8'd0, 32'h11223344, 32'hF0E0D0C0, "R1");
    cycle(0, 0, 2'd0, 8'd0, 32'hFFFFFFFF, 32'h12345678, "R9");
    cycle(0, 0, 2'd3, 8'd40, 32'h01010101, 32'h01010101, "R9");

    // R2 INT4 split products including -8*-8
    cycle(1, 1, 2'd1, 8'd0, 32'h88887F1E, 32'h8888F77E, "R2");
    cycle(1, 0, 2'd1, 8'd0, 32'h3C5A9612, 32'hE1D2C3B4, "R2");

    // R3 R4 FP8: equal exponents, spread with subnormal, flush-out lane
    cycle(1, 1, 2'd2, 8'd0, 32'h3C3A38BF, 32'h383E40B9, "R4");
    cycle(1, 1, 2'd2, 8'd0, 32'h3CC44502, 32'h3838BA40, "R3");
    cycle(1, 1, 2'd2, 8'd0, 32'h780801FF, 32'h7808F8F7, "R4");
    cycle(1, 1, 2'd2, 8'd0, 32'h03050607, 32'h81020304, "R3");
    // R6 FP8 higher block after lower, then lower after higher
    cycle(1, 0, 2'd2, 8'd0, 32'h5860687A, 32'h50485870, "R6");
    cycle(1, 0, 2'd2, 8'd0, 32'h20283038, 32'hA0283038, "R6");

    // R5 R8 MXINT: shared exponent taken directly, then falling and rising
    cycle(1, 1, 2'd3, 8'd5, 32'h7F80C040, 32'h7F7F40C0, "R8");
    cycle(1, 0, 2'd3, 8'hFD, 32'h10203040, 32'h10203040, "R5");
    cycle(1, 0, 2'd3, 8'd20, 32'h7F7F7F7F, 32'h7F7F7F7F, "R6");

    // R7 clear alone, then R8 negative exponent after clear
    cycle(0, 1, 2'd0, 8'd0, 32'h0, 32'h0, "R7");
    cycle(0, 0, 2'd0, 8'd0, 32'h0, 32'h0, "R7");
    cycle(1, 0, 2'd3, 8'hF0, 32'h01020304, 32'hFF020304, "R8");
    cycle(1, 1, 2'd0, 8'd0, 32'h00000001, 32'h00000002, "R7");

    // R6 random mixed run with occasional clears
    for (int i = 0; i < 400; i++) begin
      logic [1:0] f;
      f = 2'($urandom_range(0, 3));
      cycle(($urandom_range(0, 9) < 7), ($urandom_range(0, 19) == 0), f,
            8'($urandom), $urandom, $urandom, "R6");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1;
    $finish;
  end

endmodule